// File: doc/BRIEF.md
# Zero-Address Stack Execution Core with Register Stack Cache

This block runs a stream of stack instructions: memory push, literal push, memory pop, add and multiply. Arithmetic names no operand. It takes both sources from the top of an operand stack and leaves the result there. The top `N` entries of the stack are kept in a register window, so arithmetic never waits on memory.

Deeper entries are held in a reserved region of a word-addressed data memory. They go there through one synchronous memory port that the core shares with the explicit push and pop operands. When a push finds the window full, the oldest register entry is first written to the reserved region (a spill). When an operation needs more operands than the window holds, entries are read back first (a fill). The `busy` output marks the cycles spent on this traffic.

A host presents one instruction at a time with a valid/ready pair and watches a retire pulse and the top-of-stack value. Stack misuse is reported on two flag outputs and leaves the stack untouched.

Top module: `stk_core`

## Requirements
- R1: Opcode 3'd1 (literal push) places the 16-bit `ins_arg` on top of the stack. `tos_value` shows it when `ins_done` pulses.
- R2: Opcode 3'd0 (memory push) reads the word at address `ins_arg[7:0]` through the memory port and places it on top of the stack. The port is synchronous: read data is taken one cycle after the request.
- R3: Opcode 3'd2 (pop) removes the top entry and writes it to address `ins_arg[7:0]`. The write is complete when `ins_done` pulses.
- R4: Opcode 3'd3 (add) and opcode 3'd4 (multiply) remove the two top entries and push their two's complement sum or product, kept to the low 16 bits.
- R5: A push that finds all `N` registers occupied first writes the oldest register entry to address `BASE + s`, where `s` is the number of entries already in memory. `busy` is high during that write cycle.
- R6: An operation that needs more entries than the registers hold refills them from the most recently spilled slot, `BASE + s - 1`, before it executes. `busy` is high during the refill.
- R7: A pop with an empty stack, or an add or multiply with fewer than two entries in total, raises `unf_flag` for one cycle. The stack does not change and `ins_done` stays low.
- R8: A push when the stack already holds `N + SLOTS` entries raises `ovf_flag` for one cycle. The stack does not change and `ins_done` stays low.
- R9: The sequence push a, push b, push c, add, multiply, pop res leaves a*(b+c) in res.
- R10: `ins_ready` is high only while the core waits for an instruction, and an instruction is taken on a cycle where `ins_valid` and `ins_ready` are both high. `ins_done` pulses once per retired instruction. Opcodes 3'd5 to 3'd7 retire without changing the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Instruction present |
| ins_op | input | 3 | Opcode |
| ins_arg | input | 16 | Literal or memory address (low 8 bits) |
| ins_ready | output | 1 | Core can take an instruction |
| ins_done | output | 1 | One-cycle retire pulse |
| busy | output | 1 | Spill or fill in progress |
| tos_value | output | 16 | Top register entry, zero when the register window is empty |
| ovf_flag | output | 1 | Overflow pulse |
| unf_flag | output | 1 | Underflow pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 8 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The hardest state to reach is one where an arithmetic operation finds the register window short of operands while spilled entries wait in memory. The stimulus gets there in two steps. It first pushes past the window depth so that spills occur. It then issues a chain of adds until each add must refill one entry before it can execute. After that, the stimulus fills the whole stack to its total depth and then pushes once more, which reaches the overflow case. It then drains the stack with pops to distinct addresses, so that every spilled slot passes back through the refill path and is checked in memory.

// File: rtl/stk_pkg.sv
// Shared opcode, register-window command and controller state encodings.
package stk_pkg;
    localparam logic [2:0] OP_PUSH  = 3'd0;
    localparam logic [2:0] OP_PUSHL = 3'd1;
    localparam logic [2:0] OP_POP   = 3'd2;
    localparam logic [2:0] OP_ADD   = 3'd3;
    localparam logic [2:0] OP_MUL   = 3'd4;

    typedef enum logic [2:0] {
        RF_HOLD, RF_PUSH, RF_POP, RF_SPILL, RF_FILL, RF_BIN
    } rf_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PREP, S_SPILL, S_FREQ, S_FWAIT, S_MRD, S_MWAIT, S_EXEC
    } ctl_state_e;
endpackage

// File: rtl/stk_alu.sv
// Two-operand arithmetic unit: wrapping add or multiply on DW-bit words.
// Assumes the operands are two's complement, so the low DW bits of the
// result are the same as for unsigned operands.
module stk_alu #(
    parameter int DW = 16
) (
    input  logic          is_mul,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);
    logic [DW-1:0] sum;
    logic [DW-1:0] prod;

    // Form both results; the low DW bits of the product are kept.
    always_comb begin
        sum  = opa + opb;
        prod = opa * opb;
        res  = is_mul ? prod : sum;
    end
endmodule

// File: rtl/stk_regfile.sv
// Register window holding the top N stack entries. Entry 0 is the oldest
// and entry cnt-1 is the top. A spill shifts toward entry 0 after the
// oldest entry leaves; a fill shifts away from entry 0 to make room for a
// refilled word. Assumes the controller issues only commands that are
// legal for the current count.
module stk_regfile #(
    parameter int DW = 16,
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_pkg::rf_cmd_e  cmd,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     bin_res,
    output logic [DW-1:0]     top,
    output logic [DW-1:0]     second,
    output logic [DW-1:0]     bottom,
    output logic [CW-1:0]     cnt
);
    import stk_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [DW-1:0] regs [N];
    logic [IW-1:0] top_idx;
    logic [IW-1:0] sec_idx;
    logic [IW-1:0] put_idx;

    // Index of the top, second and next free entry.
    always_comb begin
        top_idx = IW'(cnt - CW'(1));
        sec_idx = IW'(cnt - CW'(2));
        put_idx = IW'(cnt);
    end

    // Apply one window command per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else begin
            case (cmd)
                RF_PUSH: begin
                    regs[put_idx] <= wdata;
                    cnt <= cnt + CW'(1);
                end
                RF_POP: cnt <= cnt - CW'(1);
                RF_SPILL: begin
                    for (int i = 0; i < N - 1; i++) regs[i] <= regs[i+1];
                    cnt <= cnt - CW'(1);
                end
                RF_FILL: begin
                    for (int i = 1; i < N; i++) regs[i] <= regs[i-1];
                    regs[0] <= wdata;
                    cnt <= cnt + CW'(1);
                end
                RF_BIN: begin
                    regs[sec_idx] <= bin_res;
                    cnt <= cnt - CW'(1);
                end
                default: ;
            endcase
        end
    end

    // Read ports; the top reads as zero when the window is empty.
    always_comb begin
        top    = (cnt == '0) ? '0 : regs[top_idx];
        second = regs[sec_idx];
        bottom = regs[0];
    end
endmodule

// File: rtl/stk_ctrl.sv
// Sequencer: takes instructions, checks them against the total depth,
// runs spills and fills through the memory port, and steers the register
// window and the ALU. Assumes synchronous memory with one-cycle read data.
module stk_ctrl #(
    parameter int             DW    = 16,
    parameter int             AW    = 8,
    parameter int             N     = 4,
    parameter int             SLOTS = 12,
    parameter logic [AW-1:0]  BASE  = 8'hF0,
    parameter int             CW    = $clog2(N + 1),
    parameter int             MW    = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [2:0]        ins_op,
    input  logic [DW-1:0]     ins_arg,
    output logic              ins_ready,
    output logic              ins_done,
    output logic              busy,
    output logic              ovf_flag,
    output logic              unf_flag,
    input  logic [CW-1:0]     rf_cnt,
    input  logic [DW-1:0]     rf_top,
    input  logic [DW-1:0]     rf_bottom,
    output stk_pkg::rf_cmd_e  rf_cmd,
    output logic [DW-1:0]     rf_wdata,
    output logic              alu_mul,
    output logic [MW-1:0]     msp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);
    import stk_pkg::*;

    localparam int TOTAL = N + SLOTS;
    localparam int TW    = $clog2(TOTAL + 1) + 1;

    ctl_state_e    state;
    ctl_state_e    nstate;
    logic [2:0]    op_q;
    logic [DW-1:0] arg_q;
    logic [TW-1:0] total;
    logic          in_pushy;
    logic [1:0]    in_need;
    logic          q_pushy;
    logic [1:0]    q_need;

    // Operand demand of the incoming and the held instruction.
    always_comb begin
        in_pushy = (ins_op == OP_PUSH) || (ins_op == OP_PUSHL);
        q_pushy  = (op_q == OP_PUSH) || (op_q == OP_PUSHL);
        in_need  = (ins_op == OP_POP) ? 2'd1 :
                   ((ins_op == OP_ADD) || (ins_op == OP_MUL)) ? 2'd2 : 2'd0;
        q_need   = (op_q == OP_POP) ? 2'd1 :
                   ((op_q == OP_ADD) || (op_q == OP_MUL)) ? 2'd2 : 2'd0;
        total    = TW'(rf_cnt) + TW'(msp);
    end

    // Next-state choice.
    always_comb begin
        nstate = state;
        case (state)
            S_IDLE: begin
                if (ins_valid && !(in_pushy && total == TW'(TOTAL))
                              && !(total < TW'(in_need)))
                    nstate = S_PREP;
            end
            S_PREP: begin
                if (q_pushy && rf_cnt == CW'(N))     nstate = S_SPILL;
                else if (rf_cnt < CW'(q_need))       nstate = S_FREQ;
                else if (op_q == OP_PUSH)            nstate = S_MRD;
                else                                 nstate = S_EXEC;
            end
            S_SPILL: nstate = S_PREP;
            S_FREQ:  nstate = S_FWAIT;
            S_FWAIT: nstate = S_PREP;
            S_MRD:   nstate = S_MWAIT;
            S_MWAIT: nstate = S_IDLE;
            S_EXEC:  nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // Memory port and register-window command for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rf_cmd    = RF_HOLD;
        rf_wdata  = '0;
        alu_mul   = (op_q == OP_MUL);
        case (state)
            S_SPILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = BASE + AW'(msp);
                mem_wdata = rf_bottom;
                rf_cmd    = RF_SPILL;
            end
            S_FREQ: begin
                mem_req  = 1'b1;
                mem_addr = BASE + AW'(msp) - AW'(1);
            end
            S_FWAIT: begin
                rf_cmd   = RF_FILL;
                rf_wdata = mem_rdata;
            end
            S_MRD: begin
                mem_req  = 1'b1;
                mem_addr = AW'(arg_q);
            end
            S_MWAIT: begin
                rf_cmd   = RF_PUSH;
                rf_wdata = mem_rdata;
            end
            S_EXEC: begin
                case (op_q)
                    OP_PUSHL: begin
                        rf_cmd   = RF_PUSH;
                        rf_wdata = arg_q;
                    end
                    OP_POP: begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = AW'(arg_q);
                        mem_wdata = rf_top;
                        rf_cmd    = RF_POP;
                    end
                    OP_ADD, OP_MUL: rf_cmd = RF_BIN;
                    default: rf_cmd = RF_HOLD;
                endcase
            end
            default: ;
        endcase
    end

    // State, held instruction, spill pointer and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= '0;
            arg_q    <= '0;
            msp      <= '0;
            ins_done <= 1'b0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            state    <= nstate;
            ins_done <= (state == S_MWAIT) || (state == S_EXEC);
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            if (state == S_IDLE && ins_valid) begin
                if (in_pushy && total == TW'(TOTAL)) ovf_flag <= 1'b1;
                else if (total < TW'(in_need))      unf_flag <= 1'b1;
                else begin
                    op_q  <= ins_op;
                    arg_q <= ins_arg;
                end
            end
            if (state == S_SPILL) msp <= msp + MW'(1);
            if (state == S_FREQ)  msp <= msp - MW'(1);
        end
    end

    // Handshake and traffic indication.
    always_comb begin
        ins_ready = (state == S_IDLE);
        busy      = (state == S_SPILL) || (state == S_FREQ) || (state == S_FWAIT);
    end
endmodule

// File: rtl/stk_core.sv
// Top of the stack execution core: sequencer, register window and ALU.
// Assumes the data memory region BASE..BASE+SLOTS-1 is reserved for
// spilled stack entries and not named by push or pop operands.
module stk_core #(
    parameter int             DW    = 16,
    parameter int             AW    = 8,
    parameter int             N     = 4,
    parameter int             SLOTS = 12,
    parameter logic [AW-1:0]  BASE  = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [2:0]    ins_op,
    input  logic [DW-1:0] ins_arg,
    output logic          ins_ready,
    output logic          ins_done,
    output logic          busy,
    output logic [DW-1:0] tos_value,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import stk_pkg::*;

    localparam int CW = $clog2(N + 1);
    localparam int MW = $clog2(SLOTS + 1);

    rf_cmd_e       rf_cmd;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_top;
    logic [DW-1:0] rf_second;
    logic [DW-1:0] rf_bottom;
    logic [CW-1:0] rf_cnt;
    logic [DW-1:0] alu_res;
    logic          alu_mul;
    logic [MW-1:0] msp;

    stk_ctrl #(.DW(DW), .AW(AW), .N(N), .SLOTS(SLOTS), .BASE(BASE),
               .CW(CW), .MW(MW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_op(ins_op), .ins_arg(ins_arg),
        .ins_ready(ins_ready), .ins_done(ins_done), .busy(busy),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag),
        .rf_cnt(rf_cnt), .rf_top(rf_top), .rf_bottom(rf_bottom),
        .rf_cmd(rf_cmd), .rf_wdata(rf_wdata), .alu_mul(alu_mul), .msp(msp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    stk_regfile #(.DW(DW), .N(N), .CW(CW)) u_rf (
        .clk(clk), .rst_n(rst_n), .cmd(rf_cmd), .wdata(rf_wdata),
        .bin_res(alu_res), .top(rf_top), .second(rf_second),
        .bottom(rf_bottom), .cnt(rf_cnt)
    );

    stk_alu #(.DW(DW)) u_alu (
        .is_mul(alu_mul), .opa(rf_second), .opb(rf_top), .res(alu_res)
    );

    // The visible top of stack is the top register entry.
    always_comb tos_value = rf_top;
endmodule

// File: rtl/stk_core_chk.sv
// Property checker for stk_core, attached by bind. Observes ports and the
// window count and spill pointer; drives nothing.
module stk_core_chk #(
    parameter int             DW    = 16,
    parameter int             AW    = 8,
    parameter int             N     = 4,
    parameter int             SLOTS = 12,
    parameter logic [AW-1:0]  BASE  = 8'hF0,
    parameter int             CW    = $clog2(N + 1),
    parameter int             MW    = $clog2(SLOTS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ins_ready,
    input logic          ins_done,
    input logic          busy,
    input logic [DW-1:0] tos_value,
    input logic          ovf_flag,
    input logic          unf_flag,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [CW-1:0] rf_cnt,
    input logic [MW-1:0] msp
);
    // R7: an underflow leaves the top of stack untouched.
    p_unf_keeps_tos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> ($stable(tos_value) && !ins_done));

    // R8: an overflow leaves the top of stack untouched.
    p_ovf_keeps_tos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> ($stable(tos_value) && !ins_done));

    // R7, R8: at most one flag per cycle.
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    // R8: window plus spilled entries never exceed the total depth.
    p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rf_cnt) <= N) && (32'(msp) <= SLOTS));

    // R5: a spill write lands inside the reserved stack region.
    p_spill_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req && mem_we) |->
        (mem_addr >= BASE) && (32'(mem_addr - BASE) < SLOTS));

    // R6: a refill read targets a slot that holds a spilled entry.
    p_fill_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req && !mem_we) |->
        (mem_addr >= BASE) && (32'(mem_addr - BASE) < 32'(msp)));

    // R10: no instruction is taken while memory traffic for the stack runs.
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ins_ready);

    // R10: a retire pulse follows a cycle in which no instruction was taken.
    p_done_after_work_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_done) |-> !$past(ins_ready));
endmodule

bind stk_core stk_core_chk #(.DW(DW), .AW(AW), .N(N), .SLOTS(SLOTS),
                             .BASE(BASE), .CW(CW), .MW(MW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .ins_done(ins_done),
    .busy(busy), .tos_value(tos_value), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .rf_cnt(rf_cnt), .msp(msp)
);

// File: tb/test_stk_core.sv
// Scoreboard bench: the driver predicts each instruction's outcome from
// its own stack model, the monitor compares on every retire or flag.
module test_stk_core;
    localparam int N = 4;
    localparam int SLOTS = 12;
    localparam int TOTAL = N + SLOTS;
    localparam logic [7:0] BASE = 8'hF0;

    localparam int K_TOS = 0;
    localparam int K_POP = 1;
    localparam int K_OVF = 2;
    localparam int K_UNF = 3;

    typedef struct {
        int          kind;
        logic [15:0] val;
        int          addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_op = '0;
    logic [15:0] ins_arg = '0;
    logic        ins_ready, ins_done, busy, ovf_flag, unf_flag;
    logic [15:0] tos_value;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem [256];

    exp_t        sb[$];
    logic [15:0] mdl[$];
    int checks = 0;
    int errors = 0;
    int busy_cycles = 0;
    bit wd_hit = 0;

    always #4 clk = ~clk;

    stk_core i_stk_core (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_arg(ins_arg), .ins_ready(ins_ready), .ins_done(ins_done),
        .busy(busy), .tos_value(tos_value), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous data memory.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each retire or flag with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && busy) busy_cycles++;
        if (rst_n && (ins_done || ovf_flag || unf_flag)) begin
            if (sb.size() == 0) begin
                check(0, "R10", "unexpected event", {13'd0, ins_done, ovf_flag, unf_flag}, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                case (e.kind)
                    K_TOS: check(ins_done && tos_value == e.val, e.tag, "top of stack", tos_value, e.val);
                    K_POP: check(ins_done && mem[e.addr] == e.val, e.tag, "popped word", mem[e.addr], e.val);
                    K_OVF: check(ovf_flag && !ins_done && tos_value == e.val, e.tag, "overflow top", tos_value, e.val);
                    default: check(unf_flag && !ins_done && tos_value == e.val, e.tag, "underflow top", tos_value, e.val);
                endcase
            end
        end
    end

    // Driver: predict, queue the prediction, then hand the instruction over.
    task automatic issue(input logic [2:0] op, input logic [15:0] arg, input string tag);
        exp_t e;
        int need;
        logic [15:0] a, b;
        @(negedge clk);
        while (!ins_ready) @(negedge clk);
        need = (op == 3'd2) ? 1 : ((op == 3'd3 || op == 3'd4) ? 2 : 0);
        e.tag = tag;
        e.addr = 0;
        e.val = (mdl.size() > 0) ? mdl[$] : 16'd0;
        if ((op == 3'd0 || op == 3'd1) && mdl.size() == TOTAL) begin
            e.kind = K_OVF;
        end else if (mdl.size() < need) begin
            e.kind = K_UNF;
        end else begin
            case (op)
                3'd0: begin e.kind = K_TOS; e.val = mem[arg[7:0]]; mdl.push_back(e.val); end
                3'd1: begin e.kind = K_TOS; e.val = arg; mdl.push_back(arg); end
                3'd2: begin e.kind = K_POP; e.val = mdl.pop_back(); e.addr = int'(arg[7:0]); end
                3'd3, 3'd4: begin
                    b = mdl.pop_back();
                    a = mdl.pop_back();
                    e.kind = K_TOS;
                    e.val = (op == 3'd3) ? a + b : a * b;
                    mdl.push_back(e.val);
                end
                default: e.kind = K_TOS;
            endcase
        end
        sb.push_back(e);
        ins_valid = 1'b1;
        ins_op = op;
        ins_arg = arg;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (sb.size() != 0 || !ins_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        int b0;
        // Reset state.
        check(ins_ready == 1'b1, "R10", "ready after reset", {15'd0, ins_ready}, 16'd1);
        check(busy == 1'b0 && ovf_flag == 1'b0 && unf_flag == 1'b0, "R7",
              "flags after reset", {13'd0, busy, ovf_flag, unf_flag}, 16'd0);
        check(tos_value == 16'd0, "R1", "top after reset", tos_value, 16'd0);

        // R7: underflow on an empty stack and with a single entry.
        issue(3'd2, 16'd50, "R7");
        issue(3'd3, 16'd0, "R7");
        issue(3'd1, 16'h0042, "R1");
        issue(3'd4, 16'd0, "R7");
        issue(3'd5, 16'd0, "R10");
        issue(3'd2, 16'd51, "R3");
        drain();

        // R9 and R2: a*(b+c) from memory operands.
        issue(3'd0, 16'd10, "R2");
        issue(3'd0, 16'd11, "R2");
        issue(3'd0, 16'd12, "R2");
        issue(3'd3, 16'd0, "R4");
        issue(3'd4, 16'd0, "R4");
        issue(3'd2, 16'd20, "R9");
        drain();
        check(mem[20] == 16'd27, "R9", "result word", mem[20], 16'd27);

        // R4: negative operands and product wrap.
        issue(3'd1, 16'hFFFE, "R1");
        issue(3'd1, 16'd300, "R1");
        issue(3'd4, 16'd0, "R4");
        issue(3'd1, 16'h1234, "R1");
        issue(3'd1, 16'h0100, "R1");
        issue(3'd4, 16'd0, "R4");
        issue(3'd3, 16'd0, "R4");
        issue(3'd2, 16'd21, "R4");
        drain();
        check(mem[21] == 16'h31A8, "R4", "wrapped sum", mem[21], 16'h31A8);

        // R5: six pushes spill the two oldest entries.
        b0 = busy_cycles;
        for (int i = 1; i <= 6; i++) issue(3'd1, 16'(i), "R5");
        drain();
        check(mem[BASE] == 16'd1 && mem[BASE + 8'd1] == 16'd2, "R5", "spilled slots",
              mem[BASE + 8'd1], 16'd2);
        check(busy_cycles - b0 == 2, "R5", "busy cycles on spill", 16'(busy_cycles - b0), 16'd2);

        // R6: five adds; the last two each refill one entry.
        b0 = busy_cycles;
        for (int i = 0; i < 5; i++) issue(3'd3, 16'd0, "R6");
        drain();
        check(busy_cycles - b0 == 4, "R6", "busy cycles on fill", 16'(busy_cycles - b0), 16'd4);

        // R8: fill to total depth, then one push too many.
        for (int i = 0; i < TOTAL - 1; i++) issue(3'd1, 16'(16'h0100 + i), "R8");
        issue(3'd1, 16'h0999, "R8");
        issue(3'd0, 16'd10, "R8");
        drain();

        // R3: drain every entry through pops, refilling as needed, then underflow.
        for (int i = 0; i < TOTAL; i++) issue(3'd2, 16'(64 + i), "R3");
        issue(3'd2, 16'd100, "R7");
        drain();
        check(mem[64 + TOTAL - 1] == 16'd21, "R3", "deepest entry", mem[64 + TOTAL - 1], 16'd21);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 7);
        mem[10] <= 16'd3;
        mem[11] <= 16'd4;
        mem[12] <= 16'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) check(0, "R10", "watchdog expired", {15'd0, ins_ready}, 16'd1);
        check(sb.size() == 0, "R10", "outstanding predictions", 16'(sb.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule